// File: doc/BRIEF.md
# Twelve-Bit Accumulator Processor Core

This is a small processor core built around one twelve-bit accumulator. Its other state is a link bit, a twelve-bit MQ register, a twelve-bit program counter and an interrupt enable. It runs programs from a single synchronous memory of 4096 twelve-bit words. The memory is addressed by word, and a read returns its data on the cycle after the read strobe. The core is meant for control tasks that would otherwise use hand-built sequencing logic, and it needs no external glue beyond that memory.

The instruction set has no stack and no branch instructions. A call stores its return address in the first word of the called routine. Conditionals can only step over the next word, so a two-way branch is a skip followed by a jump. A single maskable interrupt stores the program counter at word 0 and resumes at word 1. The I/O instruction group decodes only interrupt on and interrupt off.

Top module: `acc12_core`

## Requirements
- R1: While reset is low, the core clears the accumulator, link, MQ and interrupt enable, and loads the program counter with START_ADDR (default octal 0200). The first access is a read at that address.
- R2: An instruction word holds the opcode in bits 11:9, the indirect flag in bit 8, the page select in bit 7 and a seven-bit offset in bits 6:0. Page select 0 addresses page zero. Page select 1 addresses the page of the instruction itself, which is its address with bits 6:0 forced to zero.
- R3: When the indirect flag is set, the word at the formed address is read and used as the operand address.
- R4: Opcode 0 ANDs the operand into the accumulator. Opcode 1 adds the operand in two's complement, and a carry out of bit 11 inverts the link.
- R5: Opcode 3 stores the accumulator at the operand address and then clears the accumulator.
- R6: Opcode 2 writes the operand plus one back to memory and skips the next word when the written value is zero.
- R7: Opcode 4 writes the address of the following word into the target word and continues at the target plus one. Opcode 5 loads the program counter with the operand address, so an indirect jump through the target word returns from the routine.
- R8: In opcode 7 with bit 8 clear, the low bits act in this order. First bit 7 clears AC and bit 6 clears link. Then bit 5 inverts AC and bit 4 inverts link. Then bit 0 increments AC, with the carry inverting link. Last, bit 2 rotates link:AC left or bit 3 rotates it right by one, and bit 1 doubles the rotate.
- R9: In opcode 7 with bits 8 set and 0 clear, bit 6 tests AC negative, bit 5 tests AC zero and bit 4 tests link set. The tests are ORed, and bit 3 inverts the result. A true result skips the next word. Bit 7 clears AC after the test.
- R10: In opcode 7 with bits 8 and 0 set, bit 7 clears AC first. Then bit 4 alone moves AC into MQ and clears AC, bit 6 alone ORs MQ into AC, and both together swap AC and MQ.
- R11: At an instruction boundary with interrupts enabled and irq high, the core writes the program counter to word 0, continues at word 1 and clears the enable.
- R12: Opcode 6 with low bits 1 enables interrupts and with low bits 2 disables them. After an enable, one further instruction completes before an interrupt can be taken.
- R13: The read and write strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| irq | input | 1 | Interrupt request, active high, level sensed |
| mem_rd | output | 1 | Read strobe; data returns on the next cycle |
| mem_wr | output | 1 | Write strobe for mem_wdata at mem_addr |
| mem_addr | output | 12 | Word address of the current access |
| mem_wdata | output | 12 | Data to be written |
| mem_rdata | input | 12 | Read data, valid the cycle after mem_rd |

## Verification
The assertions assume that mem_rdata carries the word addressed in the previous cycle whenever mem_rd was high. They also assume that the memory holds what was last written to it. The bench meets both conditions with a behavioural memory that has a one-cycle registered read and applies writes at the clock edge. The bench raises irq only as a steady level, and only in programs that place a handler at word 1. It loads every program while reset is low, so no access from the core is pending when a program is loaded.

// File: rtl/acc12_pkg.sv
// Shared types for the twelve-bit accumulator core.
// Assumes a three-bit major opcode field at the top of the instruction word.
package acc12_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_TAD = 3'd1,
        OP_ISZ = 3'd2,
        OP_DCA = 3'd3,
        OP_JMS = 3'd4,
        OP_JMP = 3'd5,
        OP_IOT = 3'd6,
        OP_OPR = 3'd7
    } opcode_t;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_IND,
        ST_EXEC,
        ST_OPND
    } seq_state_t;

    // I/O group function codes held in the three low bits
    localparam logic [2:0] IOT_INT_ON  = 3'd1;
    localparam logic [2:0] IOT_INT_OFF = 3'd2;

endpackage

// File: rtl/acc12_ea.sv
// Forms the direct operand address of a memory-reference instruction.
// Assumes the page select flag chooses page zero (0) or the page that
// holds the instruction (1); no autoindexing is performed.
module acc12_ea #(
    parameter int WORD_W = 12,
    parameter int OFFS_W = 7,
    localparam int PAGE_W = WORD_W - OFFS_W
) (
    input  logic [OFFS_W-1:0] offset,
    input  logic              page_sel,
    input  logic [PAGE_W-1:0] cur_page,
    output logic [WORD_W-1:0] ea
);

    // Choose the page base and append the offset
    always_comb begin
        ea = {(page_sel ? cur_page : {PAGE_W{1'b0}}), offset};
    end

endmodule

// File: rtl/acc12_opr.sv
// Combinational operate-group unit: microcoded accumulator, link and MQ
// operations and skip tests. Takes the low nine instruction bits only;
// assumes the caller applies results only for the operate opcode.
module acc12_opr #(
    parameter int WORD_W = 12
) (
    input  logic [8:0]        ubits,
    input  logic [WORD_W-1:0] ac_i,
    input  logic              link_i,
    input  logic [WORD_W-1:0] mq_i,
    output logic [WORD_W-1:0] ac_o,
    output logic              link_o,
    output logic [WORD_W-1:0] mq_o,
    output logic              skip_o
);

    localparam int B_GRP  = 8;
    localparam int B_CLA  = 7;
    localparam int B_CLL  = 6;
    localparam int B_CMA  = 5;
    localparam int B_CML  = 4;
    localparam int B_RAR  = 3;
    localparam int B_RAL  = 2;
    localparam int B_TWO  = 1;
    localparam int B_IAC  = 0;
    localparam int B_SMA  = 6;
    localparam int B_SZA  = 5;
    localparam int B_SNL  = 4;
    localparam int B_REV  = 3;
    localparam int B_MQA  = 6;
    localparam int B_MQL  = 4;

    logic [WORD_W-1:0] a_v;
    logic [WORD_W-1:0] m_v;
    logic [WORD_W-1:0] t_v;
    logic [WORD_W:0]   inc_v;
    logic              l_v;
    logic              cond_v;

    // Evaluate the selected microgroup in its fixed order of steps
    always_comb begin
        a_v    = ac_i;
        l_v    = link_i;
        m_v    = mq_i;
        t_v    = '0;
        inc_v  = '0;
        cond_v = 1'b0;
        skip_o = 1'b0;
        if (!ubits[B_GRP]) begin
            if (ubits[B_CLA]) a_v = '0;
            if (ubits[B_CLL]) l_v = 1'b0;
            if (ubits[B_CMA]) a_v = ~a_v;
            if (ubits[B_CML]) l_v = ~l_v;
            if (ubits[B_IAC]) begin
                inc_v = {1'b0, a_v} + 1'b1;
                a_v   = inc_v[WORD_W-1:0];
                l_v   = l_v ^ inc_v[WORD_W];
            end
            if (ubits[B_RAL] && !ubits[B_RAR]) begin
                {l_v, a_v} = {a_v, l_v};
                if (ubits[B_TWO]) {l_v, a_v} = {a_v, l_v};
            end
            if (ubits[B_RAR] && !ubits[B_RAL]) begin
                {l_v, a_v} = {a_v[0], l_v, a_v[WORD_W-1:1]};
                if (ubits[B_TWO]) {l_v, a_v} = {a_v[0], l_v, a_v[WORD_W-1:1]};
            end
        end else if (!ubits[0]) begin
            cond_v = (ubits[B_SMA] && ac_i[WORD_W-1]) ||
                     (ubits[B_SZA] && (ac_i == '0)) ||
                     (ubits[B_SNL] && link_i);
            skip_o = ubits[B_REV] ? !cond_v : cond_v;
            if (ubits[B_CLA]) a_v = '0;
        end else begin
            if (ubits[B_CLA]) a_v = '0;
            t_v = a_v;
            if (ubits[B_MQA] && ubits[B_MQL]) begin
                a_v = m_v;
                m_v = t_v;
            end else if (ubits[B_MQA]) begin
                a_v = a_v | m_v;
            end else if (ubits[B_MQL]) begin
                m_v = a_v;
                a_v = '0;
            end
        end
        ac_o   = a_v;
        link_o = l_v;
        mq_o   = m_v;
    end

endmodule

// File: rtl/acc12_core.sv
// Twelve-bit single-accumulator core with a fetch/execute sequencer,
// page-relative and indirect addressing, call linkage through the target
// word and one maskable interrupt. Assumes a word memory whose read data
// arrives one cycle after mem_rd and whose writes land at the clock edge.
module acc12_core #(
    parameter int WORD_W     = 12,
    parameter int OFFS_W     = 7,
    parameter int START_ADDR = 'o200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    import acc12_pkg::*;

    localparam int OPC_LSB  = WORD_W - 3;
    localparam int IND_BIT  = WORD_W - 4;
    localparam int PAGE_BIT = WORD_W - 5;
    localparam int PAGE_W   = WORD_W - OFFS_W;
    localparam logic [WORD_W-1:0] START_W  = WORD_W'(START_ADDR);
    localparam logic [WORD_W-1:0] VEC_SAVE = '0;
    localparam logic [WORD_W-1:0] VEC_RUN  = WORD_W'(1);

    seq_state_t        state_q;
    opcode_t           op_q;
    logic [WORD_W-1:0] pc_q;
    logic [WORD_W-1:0] ac_q;
    logic [WORD_W-1:0] mq_q;
    logic [WORD_W-1:0] ea_q;
    logic              link_q;
    logic              ie_q;
    logic              hold_q;

    opcode_t           op_now;
    logic              is_mri;
    logic              take_int;
    logic [WORD_W-1:0] ea_dir;
    logic [WORD_W-1:0] isz_val;
    logic [WORD_W:0]   tad_sum;
    logic [WORD_W-1:0] opr_ac;
    logic [WORD_W-1:0] opr_mq;
    logic              opr_link;
    logic              opr_skip;

    assign op_now   = opcode_t'(mem_rdata[OPC_LSB +: 3]);
    assign is_mri   = (op_now != OP_IOT) && (op_now != OP_OPR);
    assign take_int = ie_q && irq && !hold_q;
    assign isz_val  = mem_rdata + 1'b1;
    assign tad_sum  = {1'b0, ac_q} + {1'b0, mem_rdata};

    acc12_ea #(
        .WORD_W (WORD_W),
        .OFFS_W (OFFS_W)
    ) u_ea (
        .offset   (mem_rdata[OFFS_W-1:0]),
        .page_sel (mem_rdata[PAGE_BIT]),
        .cur_page (pc_q[WORD_W-1:OFFS_W]),
        .ea       (ea_dir)
    );

    acc12_opr #(
        .WORD_W (WORD_W)
    ) u_opr (
        .ubits  (mem_rdata[8:0]),
        .ac_i   (ac_q),
        .link_i (link_q),
        .mq_i   (mq_q),
        .ac_o   (opr_ac),
        .link_o (opr_link),
        .mq_o   (opr_mq),
        .skip_o (opr_skip)
    );

    // Drive the memory port from the sequencer state
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = pc_q;
        mem_wdata = '0;
        unique case (state_q)
            ST_FETCH: begin
                if (take_int) begin
                    mem_wr    = 1'b1;
                    mem_addr  = VEC_SAVE;
                    mem_wdata = pc_q;
                end else begin
                    mem_rd = 1'b1;
                end
            end
            ST_DECODE: begin
                if (is_mri && mem_rdata[IND_BIT]) begin
                    mem_rd   = 1'b1;
                    mem_addr = ea_dir;
                end
            end
            ST_EXEC: begin
                mem_addr = ea_q;
                case (op_q)
                    OP_AND, OP_TAD, OP_ISZ: mem_rd = 1'b1;
                    OP_DCA: begin
                        mem_wr    = 1'b1;
                        mem_wdata = ac_q;
                    end
                    OP_JMS: begin
                        mem_wr    = 1'b1;
                        mem_wdata = pc_q;
                    end
                    default: ;
                endcase
            end
            ST_OPND: begin
                mem_addr = ea_q;
                if (op_q == OP_ISZ) begin
                    mem_wr    = 1'b1;
                    mem_wdata = isz_val;
                end
            end
            default: ;
        endcase
    end

    // Sequencer and architectural registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            op_q    <= OP_AND;
            pc_q    <= START_W;
            ac_q    <= '0;
            mq_q    <= '0;
            ea_q    <= '0;
            link_q  <= 1'b0;
            ie_q    <= 1'b0;
            hold_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_FETCH: begin
                    if (take_int) begin
                        pc_q <= VEC_RUN;
                        ie_q <= 1'b0;
                    end else begin
                        hold_q  <= 1'b0;
                        state_q <= ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    op_q    <= op_now;
                    pc_q    <= pc_q + 1'b1;
                    state_q <= ST_FETCH;
                    if (is_mri) begin
                        ea_q    <= ea_dir;
                        state_q <= mem_rdata[IND_BIT] ? ST_IND : ST_EXEC;
                    end else if (op_now == OP_IOT) begin
                        if (mem_rdata[2:0] == IOT_INT_ON) begin
                            ie_q   <= 1'b1;
                            hold_q <= 1'b1;
                        end else if (mem_rdata[2:0] == IOT_INT_OFF) begin
                            ie_q <= 1'b0;
                        end
                    end else begin
                        ac_q   <= opr_ac;
                        link_q <= opr_link;
                        mq_q   <= opr_mq;
                        if (opr_skip) pc_q <= pc_q + WORD_W'(2);
                    end
                end
                ST_IND: begin
                    ea_q    <= mem_rdata;
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    state_q <= ST_FETCH;
                    case (op_q)
                        OP_AND, OP_TAD, OP_ISZ: state_q <= ST_OPND;
                        OP_DCA: ac_q <= '0;
                        OP_JMS: pc_q <= ea_q + 1'b1;
                        OP_JMP: pc_q <= ea_q;
                        default: ;
                    endcase
                end
                ST_OPND: begin
                    state_q <= ST_FETCH;
                    case (op_q)
                        OP_AND: ac_q <= ac_q & mem_rdata;
                        OP_TAD: begin
                            ac_q   <= tad_sum[WORD_W-1:0];
                            link_q <= link_q ^ tad_sum[WORD_W];
                        end
                        OP_ISZ: if (isz_val == '0) pc_q <= pc_q + 1'b1;
                        default: ;
                    endcase
                end
                default: state_q <= ST_FETCH;
            endcase
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (pc_q == START_W && ac_q == '0 && !link_q && !ie_q)); // R1

    AST_DCA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && state_q == ST_EXEC && op_q == OP_DCA) |=> (ac_q == '0)); // R5

    AST_ISZ_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPND && op_q == OP_ISZ && mem_rdata == {WORD_W{1'b1}})
        |=> (pc_q == WORD_W'($past(pc_q) + 1'b1))); // R6

    AST_CALL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && op_q == OP_JMS)
        |=> (pc_q == WORD_W'($past(ea_q) + 1'b1) && state_q == ST_FETCH)); // R7

    AST_OPR_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && op_now == OP_OPR && opr_skip)
        |=> (pc_q == WORD_W'($past(pc_q) + 2'd2))); // R9

    AST_INT_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && mem_wr && mem_addr == VEC_SAVE)
        |=> (pc_q == VEC_RUN && !ie_q)); // R11

    AST_ION_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH && hold_q) |-> !mem_wr); // R12

    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R13

endmodule

// File: tb/tb_acc12_core.sv
// Self-checking bench: behavioural one-cycle word memory, a vector table
// of operate-group cases, then directed programs for memory reference,
// linkage, looping and the interrupt.
module tb_acc12_core;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 15;

    // {ac_in, link_in, operate word, ac_exp, link_exp, skip_exp}
    localparam logic [38:0] VEC [NV] = '{
        {12'o1234, 1'b0, 12'o7040, 12'o6543, 1'b0, 1'b0},
        {12'o0005, 1'b0, 12'o7020, 12'o0005, 1'b1, 1'b0},
        {12'o7777, 1'b0, 12'o7001, 12'o0000, 1'b1, 1'b0},
        {12'o4001, 1'b0, 12'o7004, 12'o0002, 1'b1, 1'b0},
        {12'o0003, 1'b1, 12'o7010, 12'o4001, 1'b1, 1'b0},
        {12'o4001, 1'b0, 12'o7006, 12'o0005, 1'b0, 1'b0},
        {12'o1234, 1'b0, 12'o7360, 12'o7777, 1'b1, 1'b0},
        {12'o0000, 1'b0, 12'o7440, 12'o0000, 1'b0, 1'b1},
        {12'o0005, 1'b0, 12'o7440, 12'o0005, 1'b0, 1'b0},
        {12'o4000, 1'b0, 12'o7500, 12'o4000, 1'b0, 1'b1},
        {12'o0007, 1'b1, 12'o7420, 12'o0007, 1'b1, 1'b1},
        {12'o0003, 1'b0, 12'o7450, 12'o0003, 1'b0, 1'b1},
        {12'o0000, 1'b0, 12'o7410, 12'o0000, 1'b0, 1'b1},
        {12'o0006, 1'b0, 12'o7640, 12'o0000, 1'b0, 1'b0},
        {12'o1234, 1'b0, 12'o7521, 12'o0000, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic        mem_rd;
    logic        mem_wr;
    logic [11:0] mem_addr;
    logic [11:0] mem_wdata;
    logic [11:0] mem_rdata;

    logic [11:0] mem [512];
    logic        clr = 1'b0;
    logic        ld_en = 1'b0;
    logic [8:0]  ld_a = '0;
    logic [11:0] ld_d = '0;

    int errors = 0;
    int checks = 0;
    int both_cnt = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc12_core dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    // Memory model: loader port, core writes, one-cycle registered read
    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 512; i++) mem[i] <= '0;
        end else if (ld_en) begin
            mem[ld_a] <= ld_d;
        end else if (mem_wr) begin
            mem[mem_addr[8:0]] <= mem_wdata;
        end
        if (mem_rd) mem_rdata <= mem[mem_addr[8:0]];
    end

    // Count cycles with both strobes high
    always @(negedge clk) begin
        if (rst_n && mem_rd && mem_wr) both_cnt++;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%o expected=%o", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [11:0] d);
        ld_a  = 9'(a);
        ld_d  = d;
        ld_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic begin_load();
        rst_n = 1'b0;
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic start_run(input int cycles);
        ld_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        // Reset state: first access is a read at the start address (R1)
        repeat (2) @(negedge clk);
        check("R1 rd strobe in reset", {11'b0, mem_rd}, 12'o0001);
        check("R1 wr strobe in reset", {11'b0, mem_wr}, 12'o0000);
        check("R1 start address", mem_addr, 12'o0200);

        // Operate-group vectors (R8 R9 R10)
        for (int v = 0; v < NV; v++) begin
            begin_load();
            poke('o200, 12'o7300);
            poke('o201, 12'o1020);
            poke('o202, VEC[v][26] ? 12'o7020 : 12'o7000);
            poke('o203, VEC[v][25:14]);
            poke('o204, 12'o2024);
            poke('o205, 12'o3021);
            poke('o206, 12'o7004);
            poke('o207, 12'o3022);
            poke('o210, 12'o5210);
            poke('o020, VEC[v][38:27]);
            start_run(90);
            check($sformatf("R8/R9/R10 vec%0d ac", v), mem['o021], VEC[v][13:2]);
            check($sformatf("R8/R9/R10 vec%0d link", v), mem['o022], {11'b0, VEC[v][1]});
            check($sformatf("R9 vec%0d skip", v), mem['o024], VEC[v][0] ? 12'o0000 : 12'o0001);
        end

        // Main program: AND, TAD, indirect, ISZ loop, call, interrupt
        begin_load();
        poke('o200, 12'o7300); poke('o201, 12'o1030); poke('o202, 12'o0031);
        poke('o203, 12'o3032); poke('o204, 12'o1433); poke('o205, 12'o1034);
        poke('o206, 12'o3035); poke('o207, 12'o7004); poke('o210, 12'o3036);
        poke('o211, 12'o2037); poke('o212, 12'o5211); poke('o213, 12'o4250);
        poke('o214, 12'o3041); poke('o215, 12'o6001); poke('o216, 12'o7000);
        poke('o217, 12'o2045); poke('o220, 12'o5220);
        poke('o250, 12'o0000); poke('o251, 12'o1042); poke('o252, 12'o5650);
        poke('o001, 12'o2044); poke('o002, 12'o5400);
        poke('o030, 12'o2525); poke('o031, 12'o0707); poke('o033, 12'o0040);
        poke('o040, 12'o0017); poke('o034, 12'o7775); poke('o037, 12'o7775);
        poke('o042, 12'o0123);
        irq = 1'b1;
        start_run(400);
        check("R4 AND result", mem['o032], 12'o0505);
        check("R5 store then clear", mem['o035], 12'o0014);
        check("R3 R4 indirect TAD with carry", mem['o035], 12'o0014);
        check("R4 carry inverts link", mem['o036], 12'o0001);
        check("R6 ISZ loop counter", mem['o037], 12'o0000);
        check("R7 return address in entry", mem['o250], 12'o0214);
        check("R7 R2 routine ran and returned", mem['o041], 12'o0123);
        check("R12 R11 saved PC after ION delay", mem['o000], 12'o0217);
        check("R11 handler ran once", mem['o044], 12'o0001);
        check("R11 resumed at saved PC", mem['o045], 12'o0001);

        // Interrupt off right after on: nothing taken (R12)
        begin_load();
        poke('o200, 12'o6001); poke('o201, 12'o6002);
        poke('o202, 12'o7000); poke('o203, 12'o5203);
        poke('o001, 12'o2044); poke('o002, 12'o5400);
        irq = 1'b1;
        start_run(120);
        check("R12 no save after IOF", mem['o000], 12'o0000);
        check("R12 handler not entered", mem['o044], 12'o0000);
        irq = 1'b0;

        // MQ round trip (R10)
        begin_load();
        poke('o200, 12'o7300); poke('o201, 12'o1020); poke('o202, 12'o7421);
        poke('o203, 12'o1021); poke('o204, 12'o7501); poke('o205, 12'o3022);
        poke('o206, 12'o5206);
        poke('o020, 12'o1234); poke('o021, 12'o0001);
        start_run(80);
        check("R10 MQL then MQA", mem['o022], 12'o1235);

        check("R13 strobes exclusive", 12'(both_cnt), 12'o0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule